// File: doc/BRIEF.md
# Fifth-order decimating filter for a one-bit modulator stream

This block turns the one-bit output of a delta-sigma modulator into signed 24-bit conversion words. An internal divider produces one sample enable every six system clocks. Each sampled bit counts as +1 when high and −1 when low. Five accumulators that run at the sample rate feed five difference stages that run at the output rate. Together they form a cascaded integrator-comb filter of order five with a fixed decimation of 64. The result is therefore one word every 384 system clocks.

Each new word comes with a one-clock strobe. A settled flag stays low until the filter has seen enough fresh samples for a fully valid result, which is the fifth word after any restart. A synchronous restart input clears every accumulator, every difference stage, the sample divider and the decimation counter. It is intended for use after a channel change or when several converters must be aligned.

Top module: `sinc5_decimator`

## Requirements
- R1: While reset is applied, and directly after it, `res_valid` is 0, `res_data` is 000000 and `settled` is 0.
- R2: The modulator bit is sampled once every 6 system clocks. The first sample after a restart edge is taken at the 6th following clock edge. A 1 counts as +1 and a 0 counts as −1.
- R3: `res_valid` is a one-clock pulse and occurs once per 64 samples, which is every 384 clocks. The first pulse after a restart (or reset) edge appears 385 clock edges after that edge.
- R4: Each word is computed as follows. Apply five cascaded 64-sample moving sums to the ±1 sequence, with zero history before the restart. Take the value at the last sample of each block of 64. Shift it arithmetically right by 7 bits and output it as 24-bit two's complement.
- R5: The scaled value is clipped to the 24-bit range. A settled all-ones stream reads 7FFFFF, a settled all-zeros stream reads 800000, and a settled alternating stream reads 000000.
- R6: Internal accumulators may wrap. Words stay correct over runs of any length.
- R7: `settled` is low for the first four words after a restart. It rises together with the fifth strobe and stays high until the next restart.
- R8: A restart clears all filter state synchronously. A conversion in progress is discarded. Words that follow depend only on samples taken after the restart.
- R9: The value produced by the difference stages never goes outside ±2^30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear of all filter state |
| mod_bit | input | 1 | One-bit modulator output |
| res_valid | output | 1 | One-clock strobe for a new word |
| res_data | output | 24 | Conversion word, two's complement |
| settled | output | 1 | High from the fifth word after a restart |

## Verification
The embedded properties check the following on every cycle:
- the sample enable never fires on two neighbouring clocks;
- the result strobe is one clock wide;
- the settled flag only rises together with a strobe and holds until a restart;
- a restart empties the outputs on the next clock;
- the difference-stage output stays within its range.

The numerical value of each word can only be shown by the bench scenarios, which compare the words against an independent moving-sum model. The same applies to the 384-clock spacing and the 385-clock first latency, the clipping at both full-scale ends, and correctness after the accumulators have wrapped many times.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;

   // Accumulator width: gain bits plus one sign bit plus one guard bit,
   // so that +2^gain and -2^gain are both representable.
   function automatic int unsigned acc_width(input int unsigned order,
                                             input int unsigned ratio_log2);
      return order * ratio_log2 + 2;
   endfunction

endpackage

// File: rtl/sinc_ce_div.sv
module sinc_ce_div #(
   parameter int unsigned DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic ce
);
   localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart)        cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign ce = (cnt_q == LAST) && !restart;

   // R2: enables are separated by at least one idle clock
   assert_ce_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ce |=> !ce);

endmodule

// File: rtl/sinc_integ.sv
module sinc_integ #(
   parameter int unsigned ORDER = 5,
   parameter int unsigned W     = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                ce,
   input  logic                bit_in,
   output logic signed [W-1:0] acc_out
);
   localparam logic signed [W-1:0] PLUS_ONE = W'(1);

   // chain[k] feeds stage k; chain[k+1] is the next value of stage k
   logic signed [W-1:0] chain [ORDER+1];

   assign chain[0] = bit_in ? PLUS_ONE : '1;

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      logic signed [W-1:0] acc_q;

      assign chain[k+1] = acc_q + chain[k];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       acc_q <= '0;
         else if (restart) acc_q <= '0;
         else if (ce)      acc_q <= chain[k+1];
      end
   end

   assign acc_out = g_stage[ORDER-1].acc_q;

endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
   parameter int unsigned ORDER     = 5,
   parameter int unsigned W         = 32,
   parameter int unsigned GAIN_LOG2 = 30
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                fire,
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] dout,
   output logic                dvalid
);
   localparam logic signed [W-1:0] BOUND = W'(1) <<< GAIN_LOG2;

   logic signed [W-1:0] link [ORDER+1];

   assign link[0] = din;

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      logic signed [W-1:0] prev_q;

      assign link[k+1] = link[k] - prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       prev_q <= '0;
         else if (restart) prev_q <= '0;
         else if (fire)    prev_q <= link[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout   <= '0;
         dvalid <= 1'b0;
      end else if (restart) begin
         dout   <= '0;
         dvalid <= 1'b0;
      end else begin
         dvalid <= fire;
         if (fire) dout <= link[ORDER];
      end
   end

   // R9: the difference stages never leave the filter's gain range
   assert_comb_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid |-> (dout <= BOUND && dout >= -BOUND));

endmodule

// File: rtl/sinc_outsat.sv
module sinc_outsat #(
   parameter int unsigned W     = 32,
   parameter int unsigned OUT_W = 24,
   parameter int unsigned SHIFT = 7
) (
   input  logic signed [W-1:0] din,
   output logic [OUT_W-1:0]    dout
);
   localparam logic signed [W-1:0] MAX_V = W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
   localparam logic signed [W-1:0] MIN_V = ~MAX_V;

   logic signed [W-1:0] scaled;

   assign scaled = din >>> SHIFT;

   always_comb begin
      if (scaled > MAX_V)      dout = MAX_V[OUT_W-1:0];
      else if (scaled < MIN_V) dout = MIN_V[OUT_W-1:0];
      else                     dout = scaled[OUT_W-1:0];
   end

endmodule

// File: rtl/sinc5_decimator.sv
module sinc5_decimator
   import sinc5_pkg::*;
#(
   parameter int unsigned SYS_DIV    = 6,
   parameter int unsigned RATIO_LOG2 = 6,
   parameter int unsigned ORDER      = 5,
   parameter int unsigned OUT_W      = 24,
   parameter int unsigned SETTLE_N   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             mod_bit,
   output logic             res_valid,
   output logic [OUT_W-1:0] res_data,
   output logic             settled
);
   localparam int unsigned GAIN_LOG2 = ORDER * RATIO_LOG2;
   localparam int unsigned ACC_W     = acc_width(ORDER, RATIO_LOG2);
   localparam int          SHIFT     = int'(GAIN_LOG2) + 1 - int'(OUT_W);
   localparam int unsigned SHIFT_U   = (SHIFT < 0) ? 0 : SHIFT;
   localparam int unsigned SCNT_W    = $clog2(SETTLE_N + 1);
   localparam logic [SCNT_W-1:0] SETTLE_V = SCNT_W'(SETTLE_N);

   if (SYS_DIV < 2) begin : g_chk_div
      $error("SYS_DIV must be at least 2");
   end
   if (RATIO_LOG2 < 1 || ORDER < 1) begin : g_chk_shape
      $error("RATIO_LOG2 and ORDER must be at least 1");
   end
   if (SHIFT < 0) begin : g_chk_width
      $error("OUT_W exceeds the filter gain plus sign");
   end
   if (SETTLE_N < 1) begin : g_chk_settle
      $error("SETTLE_N must be at least 1");
   end

   logic                    ce;
   logic [RATIO_LOG2-1:0]   dec_cnt;
   logic                    fire_q;
   logic signed [ACC_W-1:0] integ_out;
   logic signed [ACC_W-1:0] comb_out;
   logic [SCNT_W-1:0]       res_cnt;

   sinc_ce_div #(.DIV(SYS_DIV)) i_div (
      .clk(clk), .rst_n(rst_n), .restart(restart), .ce(ce)
   );

   sinc_integ #(.ORDER(ORDER), .W(ACC_W)) i_integ (
      .clk(clk), .rst_n(rst_n), .restart(restart), .ce(ce),
      .bit_in(mod_bit), .acc_out(integ_out)
   );

   // decimation counter and comb trigger (one clock after the 64th sample)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_cnt <= '0;
         fire_q  <= 1'b0;
      end else if (restart) begin
         dec_cnt <= '0;
         fire_q  <= 1'b0;
      end else begin
         fire_q <= ce && (dec_cnt == '1);
         if (ce) dec_cnt <= dec_cnt + 1'b1;
      end
   end

   sinc_comb #(.ORDER(ORDER), .W(ACC_W), .GAIN_LOG2(GAIN_LOG2)) i_comb (
      .clk(clk), .rst_n(rst_n), .restart(restart), .fire(fire_q),
      .din(integ_out), .dout(comb_out), .dvalid(res_valid)
   );

   sinc_outsat #(.W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT_U)) i_sat (
      .din(comb_out), .dout(res_data)
   );

   // settle tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              res_cnt <= '0;
      else if (restart)                        res_cnt <= '0;
      else if (fire_q && res_cnt != SETTLE_V)  res_cnt <= res_cnt + 1'b1;
   end

   assign settled = (res_cnt == SETTLE_V);

   // R3: the word strobe lasts one clock
   assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R7: once settled, the flag holds until a restart
   assert_settled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && !restart) |=> settled);

   // R7: the flag only rises together with a new word
   assert_settled_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled) |-> res_valid);

   // R8: a restart empties the outputs on the next clock
   assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!res_valid && !settled && res_data == '0));

endmodule

// File: tb/test_sinc5_decimator.sv
module test_sinc5_decimator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart = 1'b0;
   logic        mod_bit = 1'b0;
   logic        res_valid;
   logic [23:0] res_data;
   logic        settled;

   sinc5_decimator i_sinc5_decimator (
      .clk(clk), .rst_n(rst_n), .restart(restart), .mod_bit(mod_bit),
      .res_valid(res_valid), .res_data(res_data), .settled(settled)
   );

   always #4 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int mode     = 0;   // 0 ones, 1 zeros, 2 alternating, 3 random
   int dens     = 50;
   int nres     = 0;
   int nsamp    = 0;
   int widx     = 0;
   bit prev_valid = 1'b0;
   bit done = 1'b0;
   logic [23:0] last_data = '0;
   logic        last_settled = 1'b0;
   longint hist [5][64];
   longint msum [5];
   longint expq [$];

   always @(posedge clk) begin
      if (!rst_n || restart) cyc <= 0;
      else                   cyc <= cyc + 1;
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] scale_exp(input longint r);
      longint y;
      y = r >>> 7;
      if (y > 64'sd8388607)  y = 64'sd8388607;
      if (y < -64'sd8388608) y = -64'sd8388608;
      return y[23:0];
   endfunction

   task automatic model_clear();
      for (int k = 0; k < 5; k++) begin
         msum[k] = 0;
         for (int j = 0; j < 64; j++) hist[k][j] = 0;
      end
      widx  = 0;
      nsamp = 0;
      nres  = 0;
      expq.delete();
   endtask

   task automatic model_push(input bit b);
      longint x;
      x = b ? 64'sd1 : -64'sd1;
      for (int k = 0; k < 5; k++) begin
         longint old;
         old = hist[k][widx];
         hist[k][widx] = x;
         msum[k] += x - old;
         x = msum[k];
      end
      widx = (widx + 1) % 64;
      nsamp++;
      if (nsamp % 64 == 0) expq.push_back(longint'(scale_exp(msum[4])));
   endtask

   function automatic bit gen_bit();
      case (mode)
         0:       return 1'b1;
         1:       return 1'b0;
         2:       return nsamp[0];
         default: return ($urandom % 100) < dens;
      endcase
   endfunction

   // monitor and bit driver, both away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && cyc == 0) begin
            chk("R8 valid cleared by restart", res_valid, 0);
            chk("R8 settled cleared by restart", settled, 0);
            chk("R8 data cleared by restart", res_data, 0);
         end
         if (cyc == 0) model_clear();
         if (prev_valid) chk("R3 strobe width", res_valid, 0);
         if (res_valid) begin
            longint e;
            nres++;
            e = (expq.size() > 0) ? expq.pop_front() : -1;
            chk("R4 R2 word value", res_data, e);
            chk("R7 settled flag", settled, (nres >= 5) ? 1 : 0);
            chk("R3 strobe timing", cyc, 385 + 384 * (nres - 1));
            last_data    = res_data;
            last_settled = settled;
         end
         prev_valid = res_valid;
         if (cyc % 6 == 0) begin
            mod_bit = gen_bit();
            model_push(mod_bit);
         end
      end
   end

   task automatic do_restart(input int hold);
      @(negedge clk);
      restart = 1'b1;
      repeat (hold) @(negedge clk);
      restart = 1'b0;
      @(negedge clk);
   endtask

   task automatic wait_results(input int n);
      while (nres < n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", res_valid, 0);
      chk("R1 data in reset", res_data, 0);
      chk("R1 settled in reset", settled, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", res_valid, 0);
      chk("R1 settled after reset", settled, 0);

      // positive full scale
      mode = 0;
      wait_results(8);
      chk("R5 positive full scale", last_data, 24'h7FFFFF);
      chk("R7 settled after eight words", last_settled, 1);

      // negative full scale
      do_restart(1);
      mode = 1;
      wait_results(6);
      chk("R5 negative full scale", last_data, 24'h800000);

      // balanced stream
      do_restart(1);
      mode = 2;
      wait_results(6);
      chk("R5 balanced zero", last_data, 24'h000000);

      // random streams, then a density change without restart
      do_restart(1);
      mode = 3; dens = 50;
      wait_results(10);
      dens = 80;
      wait_results(16);

      // restart in the middle of a conversion
      repeat (200) @(negedge clk);
      do_restart(1);
      dens = 30;
      wait_results(6);

      // long run: accumulators wrap many times
      do_restart(1);
      mode = 0;
      wait_results(40);
      chk("R6 full scale after long run", last_data, 24'h7FFFFF);
      chk("R7 still settled after long run", last_settled, 1);

      // restart held for several clocks
      repeat (100) @(negedge clk);
      do_restart(3);
      mode = 3; dens = 65;
      wait_results(5);
      chk("R7 settled at fifth word", last_settled, 1);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule